// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block decides which way of an N-way set-associative cache to evict. Each set holds one "used" flag per way and one rotating replacement pointer. Every access to a way, whether a hit or the fill that follows a miss, raises that way's flag. If raising it would leave every flag in the set high, the block instead clears all flags in the set except the one just touched. This keeps at least one way eligible at all times.

When the cache controller asks for a victim, the block searches one set in a single cycle. The search starts at the set's pointer and moves upward through the way numbers, wrapping at the top. It returns the first way whose flag is clear, and the set's pointer then moves to the way just after that victim.

Tag matching, data storage and the write-back of dirty lines are handled by the surrounding cache. The block only keeps replacement state.

Top module: `nru_replacer`

## Requirements
- R1: After reset every used flag and every set pointer is 0, and `victimValid` is low; the first victim request to any set returns way 0.
- R2: A cycle with `accessEn` high sets the used flag of way `accessWay` (binary way number) in set `setIdx`.
- R3: When an access would leave all used flags of the set at 1, every flag of that set except the accessed way's is cleared to 0 instead.
- R4: A way is returned as a victim only if its used flag was 0.
- R5: The search visits ways in increasing binary way number, starting at the set's pointer and wrapping from WAYS-1 to 0, and returns the first way whose flag is 0.
- R6: Each set has its own pointer. After a victim is returned, that set's pointer becomes (victim + 1) mod WAYS. Accesses leave the pointer unchanged.
- R7: `victimValid` is high in exactly the cycle after a cycle with `victimReq` high, with `victimWay` holding the chosen way; it is low in every other cycle.
- R8: When `accessEn` and `victimReq` are both high in one cycle, the victim is chosen from the flags as they stood before that access, and the access is still applied.
- R9: State changes made through one set have no effect on the victims chosen in any other set.
- R10: Every victim request is answered with a valid victim, because no access leaves a set with all flags at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| setIdx | input | log2(SETS) | Set addressed by both the access and the victim request |
| accessEn | input | 1 | Marks way `accessWay` of the set as used |
| accessWay | input | log2(WAYS) | Way being accessed |
| victimReq | input | 1 | Request a victim for the set |
| victimWay | output | log2(WAYS) | Chosen victim, registered |
| victimValid | output | 1 | `victimWay` is valid this cycle |

## Verification
A victim search and a used-flag update can fall in the same cycle on the same set. This matters most when that update saturates the set or touches the way the search would otherwise pick.

The bench drives both strobes together on sets whose free ways and pointer are already known. It then confirms three things:
- the returned way comes from the flags as they stood before the access;
- the access is still applied;
- the pointer has advanced.

The last two are confirmed through later victim requests to the same set, compared against a reference model. A long pseudo-random mix of both operations, often overlapping, is checked against that model as well.

// File: rtl/nru_pkg.sv
package nru_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic markUsed;    // apply the access to the used flags
    logic takeVictim;  // capture a victim and advance the pointer
  } nruStrobes_t;

endpackage

// File: rtl/nru_rotsearch.sv
module nru_rotsearch #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  usedMask,
  input  logic [WAY_W-1:0] startPtr,
  output logic             found,
  output logic [WAY_W-1:0] pick
);

  // rotFree[k] is set when the way k steps past the pointer is eligible
  logic [WAYS-1:0] rotFree;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_rot
      logic [WAY_W-1:0] slot;
      assign slot       = startPtr + WAY_W'(g);
      assign rotFree[g] = ~usedMask[slot];
    end
  endgenerate

  logic [WAY_W-1:0] offset;

  always_comb begin
    offset = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      if (rotFree[k]) offset = WAY_W'(k);
    end
  end

  assign found = |rotFree;
  assign pick  = startPtr + offset;

endmodule

// File: rtl/nru_ctrl.sv
module nru_ctrl
  import nru_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accessEn,
  input  logic        victimReq,
  input  logic        victimFound,
  output nruStrobes_t strobes,
  output logic        victimValid
);

  always_comb begin
    strobes.markUsed   = accessEn;
    strobes.takeVictim = victimReq & victimFound;
  end

  always_ff @(posedge clk) begin
    if (!rstN) victimValid <= 1'b0;
    else       victimValid <= strobes.takeVictim;
  end

endmodule

// File: rtl/nru_datapath.sv
module nru_datapath
  import nru_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic [WAY_W-1:0] accessWay,
  input  nruStrobes_t      strobes,
  output logic             victimFound,
  output logic [WAY_W-1:0] victimWay,
  output logic [WAYS-1:0]  usedRow
);

  logic [WAYS-1:0]  usedMem [SETS];
  logic [WAY_W-1:0] ptrMem  [SETS];

  logic [WAYS-1:0]  wayOneHot;
  logic [WAYS-1:0]  mergedRow;
  logic [WAYS-1:0]  nextRow;
  logic [WAY_W-1:0] searchPick;

  assign usedRow   = usedMem[setIdx];
  assign wayOneHot = WAYS'(1) << accessWay;
  assign mergedRow = usedRow | wayOneHot;
  // On saturation only the accessed way stays marked
  assign nextRow   = (&mergedRow) ? wayOneHot : mergedRow;

  nru_rotsearch #(.WAYS(WAYS)) u_search (
    .usedMask (usedRow),
    .startPtr (ptrMem[setIdx]),
    .found    (victimFound),
    .pick     (searchPick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        usedMem[s] <= '0;
        ptrMem[s]  <= '0;
      end
      victimWay <= '0;
    end else begin
      if (strobes.markUsed) usedMem[setIdx] <= nextRow;
      if (strobes.takeVictim) begin
        ptrMem[setIdx] <= searchPick + WAY_W'(1);
        victimWay      <= searchPick;
      end
    end
  end

endmodule

// File: rtl/nru_replacer.sv
module nru_replacer
  import nru_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic             accessEn,
  input  logic [WAY_W-1:0] accessWay,
  input  logic             victimReq,
  output logic [WAY_W-1:0] victimWay,
  output logic             victimValid
);

  nruStrobes_t     strobes;
  logic            victimFound;
  logic [WAYS-1:0] usedRow;

  nru_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .accessEn    (accessEn),
    .victimReq   (victimReq),
    .victimFound (victimFound),
    .strobes     (strobes),
    .victimValid (victimValid)
  );

  nru_datapath #(.WAYS(WAYS), .SETS(SETS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .setIdx      (setIdx),
    .accessWay   (accessWay),
    .strobes     (strobes),
    .victimFound (victimFound),
    .victimWay   (victimWay),
    .usedRow     (usedRow)
  );

endmodule

// File: rtl/nru_replacer_chk.sv
module nru_replacer_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [SET_W-1:0] setIdx,
  input logic             accessEn,
  input logic [WAY_W-1:0] accessWay,
  input logic             victimReq,
  input logic [WAY_W-1:0] victimWay,
  input logic             victimValid,
  input logic [WAYS-1:0]  usedRow
);

  logic [WAYS-1:0] prevRow;
  always_ff @(posedge clk) prevRow <= usedRow;

  // R2: the accessed way reads back as used in the following cycle
  assert_mark_used_R2: assert property (@(posedge clk) disable iff (!rstN)
    accessEn |=> (setIdx != $past(setIdx)) || usedRow[$past(accessWay)]);

  // R3 and R10: a set never holds all flags high
  assert_never_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(&usedRow));

  // R4: the returned way was unused when it was picked
  assert_victim_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> !prevRow[victimWay]);

  // R7: each request is answered in the next cycle
  assert_answer_next_R7: assert property (@(posedge clk) disable iff (!rstN)
    victimReq |=> victimValid);

  // R7: no answer without a request
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> $past(victimReq));

endmodule

bind nru_replacer nru_replacer_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .setIdx      (setIdx),
  .accessEn    (accessEn),
  .accessWay   (accessWay),
  .victimReq   (victimReq),
  .victimWay   (victimWay),
  .victimValid (victimValid),
  .usedRow     (usedRow)
);

// File: tb/nru_replacer_tb.sv
`timescale 1ns/1ps
module nru_replacer_tb;

  localparam int WAYS = 4;
  localparam int SETS = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] setIdx = '0;
  logic       accessEn = 1'b0;
  logic [1:0] accessWay = '0;
  logic       victimReq = 1'b0;
  logic [1:0] victimWay;
  logic       victimValid;

  always #4 clk = ~clk;   // 125 MHz

  nru_replacer #(.WAYS(WAYS), .SETS(SETS)) u_dut (
    .clk(clk), .rstN(rstN), .setIdx(setIdx), .accessEn(accessEn),
    .accessWay(accessWay), .victimReq(victimReq),
    .victimWay(victimWay), .victimValid(victimValid)
  );

  typedef struct {
    int    due;
    int    way;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  started = 1'b0;
  bit  done = 1'b0;

  // reference state
  bit usedM [SETS][WAYS];
  int ptrM  [SETS];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int modelVictim(int s);
    for (int k = 0; k < WAYS; k++) begin
      int w;
      w = (ptrM[s] + k) % WAYS;
      if (!usedM[s][w]) begin
        ptrM[s] = (w + 1) % WAYS;
        return w;
      end
    end
    return -1;
  endfunction

  function automatic void modelAccess(int s, int w);
    bit full;
    usedM[s][w] = 1'b1;
    full = 1'b1;
    for (int k = 0; k < WAYS; k++) if (!usedM[s][k]) full = 1'b0;
    if (full) for (int k = 0; k < WAYS; k++) usedM[s][k] = (k == w);
  endfunction

  // Driver: one cycle per call, called at a falling edge
  task automatic drive(int s, bit acc, int w, bit req, string tag);
    expItem_t it;
    setIdx    = 4'(s);
    accessEn  = acc;
    accessWay = 2'(w);
    victimReq = req;
    if (req) begin
      it.due = cyc + 1;
      it.way = modelVictim(s);   // pre-access state (R8)
      it.tag = tag;
      expQ.push_back(it);
    end
    if (acc) modelAccess(s, w);
    @(negedge clk);
    accessEn  = 1'b0;
    victimReq = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (started) begin
        if (expQ.size() > 0 && expQ[0].due == cyc) begin
          expItem_t it;
          it = expQ.pop_front();
          checks++;
          if (!victimValid || victimWay != 2'(it.way)) begin
            errors++;
            $display("FAIL %s: valid=%0b way=%0d expected valid=1 way=%0d",
                     it.tag, victimValid, victimWay, it.way);
          end
        end else if (victimValid) begin
          checks++;
          errors++;
          $display("FAIL R7: valid=1 way=%0d expected valid=0", victimWay);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      ptrM[s] = 0;
      for (int w = 0; w < WAYS; w++) usedM[s][w] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (victimValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b expected 0", victimValid);
    end
    started = 1'b1;
    @(negedge clk);

    // R1: fresh set picks way 0
    drive(3, 0, 0, 1, "R1");

    // R2, R4: ways 0 and 1 marked, victim skips them
    drive(0, 1, 0, 0, "");
    drive(0, 1, 1, 0, "");
    drive(0, 0, 0, 1, "R2");
    // R5, R6: pointer now 3, then wraps past used ways to 2
    drive(0, 0, 0, 1, "R6");
    drive(0, 0, 0, 1, "R5");

    // R3: fourth access saturates the set; only way 3 stays marked
    drive(1, 1, 0, 0, "");
    drive(1, 1, 1, 0, "");
    drive(1, 1, 2, 0, "");
    drive(1, 1, 3, 0, "");
    drive(1, 0, 0, 1, "R3");
    drive(1, 0, 0, 1, "R3");
    drive(1, 0, 0, 1, "R3");

    // R8: access and request in the same cycle
    drive(2, 1, 0, 0, "");
    drive(2, 1, 1, 0, "");
    drive(2, 1, 2, 1, "R8");
    drive(2, 0, 0, 1, "R8");
    // R8: concurrent access that saturates, victim from old flags
    drive(4, 1, 1, 0, "");
    drive(4, 1, 2, 0, "");
    drive(4, 1, 3, 0, "");
    drive(4, 1, 0, 1, "R8");
    drive(4, 0, 0, 1, "R8");

    // R9: untouched set unaffected
    drive(5, 0, 0, 1, "R9");

    // R7: idle cycles, no answer expected
    repeat (3) @(negedge clk);

    // R10: pseudo-random mix compared with the model
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 4;
      drive($urandom % SETS, r != 1, $urandom % WAYS, r != 0, "R10");
    end

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R7: %0d answers missing, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule